// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Register Writer

This block is a small hardware sequencer that programs tuning values into a PHY's internal parameter space. The parameter space is reachable only through one memory-mapped control register. Each parameter bit needs its own address, a data bit and a strobe pulse on a per-PHY strobe line. The writer takes a start pulse together with a PHY index, a starting parameter address, a data word, a bit count and a variant flag. It then issues the register writes for every bit, least significant bit first, on a write-enable/value bus.

The block keeps a shadow copy of the control register, so every write it issues carries the current contents. Only the fields the sequence touches change between writes. When the variant flag is set, the whole register is cleared once before the first bit. This is needed for newer register layouts. Typical uses are a 5-bit transmit amplitude/rate value (0x14 at address 0x20), a 1-bit calibration enable (1 at address 0x0c, PHY 0 only), a 2-bit disconnect threshold at 0x2a, and a 2-bit squelch control at 0x3c. For the squelch control, 0 enables detection and 2 disables it.

Top module: `phy_tune_writer`

## Requirements
- R1: After reset, busy_o, done_o and wr_en_o are 0 and wr_data_o equals the RST_VAL parameter (default 0x5A5A0022).
- R2: For bit i of a transfer, wr_data_o[15:8] carries (addr_i + i) modulo 256, and bit 7 carries data_i[i]. Bits are sent with index 0 first.
- R3: Each bit takes exactly four consecutive writes in this order: load the address field; set bit 7 to the data bit with the strobe cleared; set the strobe; clear the strobe. The strobe of PHY p is bit 2*p.
- R4: The strobe bit of the active PHY is high in exactly one write, and the write that follows it clears it.
- R5: When zero_first_i is 1 at start, one write of value 0 comes before the first bit write. When it is 0, no such write is made.
- R6: Every bit other than [15:8], bit 7 and the active PHY's strobe keeps its value across all writes of a transfer, except for the R5 zero write.
- R7: busy_o is high from the cycle after an accepted start until done_o rises. done_o is high for exactly one cycle, one cycle after the final write, and busy_o is low in that cycle. With W writes and a start sampled at clock edge 0, done_o is high after edge W+1.
- R8: A start while busy_o is high is ignored. It causes no extra writes and does not change the transfer in progress.
- R9: A length of 0 makes no bit writes. Only the R5 zero write is made when zero_first_i is set.
- R10: A length greater than DATA_W is treated as DATA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled when idle |
| phy_idx_i | input | PHY_W (2) | PHY whose strobe is pulsed |
| addr_i | input | ADDR_W (8) | First parameter address |
| data_i | input | DATA_W (8) | Value to write, LSB first |
| len_i | input | LEN_W (4) | Number of bits to write |
| zero_first_i | input | 1 | Clear the register once before the first bit |
| wr_en_o | output | 1 | Control register write strobe |
| wr_data_o | output | REG_W (32) | Control register write value |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked on every cycle: writes happen only while busy; the strobe write is always followed by a write that clears it; bits outside the touched fields stay stable from one write to the next; done is a single-cycle pulse with busy low; and the latched target does not change during a transfer. The exact write values, their order, the address increment and wrap, the zero-first write, length clamping, the done cycle and the rejection of a start while busy are shown only by the bench. The bench sweeps every PHY, both variants and lengths from 0 past DATA_W, and compares the result with an arithmetic model of the register.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ZERO, ST_ADDR, ST_DATA, ST_STB_HI, ST_STB_LO, ST_FIN
  } step_e;
  localparam int FLD_ADDR_LSB = 8;
  localparam int FLD_DATA_BIT = 7;
endpackage

// File: rtl/ptw_step_fsm.sv
module ptw_step_fsm
  import phy_tune_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             zero_first_i,
  output step_e            step_o,
  output logic             accept_o,
  output logic [LEN_W-1:0] bit_idx_o,
  output logic             done_o
);
  step_e            step_q;
  logic [LEN_W-1:0] len_q, idx_q, idx_nx;
  logic             done_q;

  assign accept_o  = start_i && (step_q == ST_IDLE);
  assign idx_nx    = idx_q + LEN_W'(1);
  assign step_o    = step_q;
  assign bit_idx_o = idx_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      len_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (step_q == ST_FIN);
      unique case (step_q)
        ST_IDLE: if (accept_o) begin
          len_q <= len_i;
          idx_q <= '0;
          if (zero_first_i)      step_q <= ST_ZERO;
          else if (len_i == '0)  step_q <= ST_FIN;
          else                   step_q <= ST_ADDR;
        end
        ST_ZERO:   step_q <= (len_q == '0) ? ST_FIN : ST_ADDR;
        ST_ADDR:   step_q <= ST_DATA;
        ST_DATA:   step_q <= ST_STB_HI;
        ST_STB_HI: step_q <= ST_STB_LO;
        ST_STB_LO: begin
          if (idx_nx == len_q) step_q <= ST_FIN;
          else begin
            idx_q  <= idx_nx;
            step_q <= ST_ADDR;
          end
        end
        ST_FIN:  step_q <= ST_IDLE;
        default: step_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_shift.sv
module ptw_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              lsb_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= sh_q >> 1;
  end

  assign lsb_o = sh_q[0];
endmodule

// File: rtl/ptw_reg_next.sv
module ptw_reg_next
  import phy_tune_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 8,
  parameter int N_PHY  = 4,
  parameter int PHY_W  = 2
) (
  input  step_e             step_i,
  input  logic [REG_W-1:0]  cur_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bit_i,
  input  logic [PHY_W-1:0]  phy_i,
  output logic [REG_W-1:0]  next_o,
  output logic              wr_o
);
  logic [REG_W-1:0] stb_mask;

  // strobe of PHY p lives at bit 2*p
  for (genvar b = 0; b < REG_W; b++) begin : g_mask
    if ((b % 2 == 0) && (b / 2 < N_PHY)) begin : g_stb
      assign stb_mask[b] = (phy_i == PHY_W'(b / 2));
    end else begin : g_none
      assign stb_mask[b] = 1'b0;
    end
  end

  always_comb begin
    next_o = cur_i;
    wr_o   = 1'b1;
    unique case (step_i)
      ST_ZERO:   next_o = '0;
      ST_ADDR:   next_o[FLD_ADDR_LSB +: ADDR_W] = addr_i;
      ST_DATA: begin
        next_o = cur_i & ~stb_mask;
        next_o[FLD_DATA_BIT] = bit_i;
      end
      ST_STB_HI: next_o = cur_i | stb_mask;
      ST_STB_LO: next_o = cur_i & ~stb_mask;
      default:   wr_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/phy_tune_writer.sv
module phy_tune_writer
  import phy_tune_pkg::*;
#(
  parameter int          REG_W   = 32,
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 8,
  parameter int          N_PHY   = 4,
  parameter logic [31:0] RST_VAL = 32'h5A5A_0022,
  localparam int PHY_W = (N_PHY > 1) ? $clog2(N_PHY) : 1,
  localparam int LEN_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PHY_W-1:0]  phy_idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              zero_first_i,
  output logic              wr_en_o,
  output logic [REG_W-1:0]  wr_data_o,
  output logic              busy_o,
  output logic              done_o
);
  step_e             step;
  logic              accept, bit_val, wr_req;
  logic [LEN_W-1:0]  len_eff, bit_idx;
  logic [PHY_W-1:0]  phy_q;
  logic [ADDR_W-1:0] addr_q, cur_addr;
  logic [REG_W-1:0]  shadow_q, shadow_nx;
  logic              wr_en_q;

  assign len_eff  = (len_i > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : len_i;
  assign cur_addr = addr_q + ADDR_W'(bit_idx);

  ptw_step_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .len_i       (len_eff),
    .zero_first_i(zero_first_i),
    .step_o      (step),
    .accept_o    (accept),
    .bit_idx_o   (bit_idx),
    .done_o      (done_o)
  );

  ptw_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .data_i (data_i),
    .shift_i(step == ST_STB_LO),
    .lsb_o  (bit_val)
  );

  ptw_reg_next #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .N_PHY(N_PHY), .PHY_W(PHY_W)
  ) u_next (
    .step_i(step),
    .cur_i (shadow_q),
    .addr_i(cur_addr),
    .bit_i (bit_val),
    .phy_i (phy_q),
    .next_o(shadow_nx),
    .wr_o  (wr_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_q    <= '0;
      addr_q   <= '0;
      shadow_q <= REG_W'(RST_VAL);
      wr_en_q  <= 1'b0;
    end else begin
      if (accept) begin
        phy_q  <= phy_idx_i;
        addr_q <= addr_i;
      end
      if (wr_req) shadow_q <= shadow_nx;
      wr_en_q <= wr_req;
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_data_o = shadow_q;
  assign busy_o    = (step != ST_IDLE);
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 8,
  parameter int N_PHY  = 4,
  parameter int PHY_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              wr_en_o,
  input logic [REG_W-1:0]  wr_data_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [PHY_W-1:0]  phy_q,
  input logic [ADDR_W-1:0] addr_q
);
  logic [REG_W-1:0] keep_mask;
  logic             stb_now;

  always_comb begin
    keep_mask = '1;
    keep_mask[8 +: ADDR_W] = '0;
    keep_mask[7] = 1'b0;
    for (int p = 0; p < N_PHY; p++)
      if (phy_q == PHY_W'(p)) keep_mask[2*p] = 1'b0;
  end
  assign stb_now = |(wr_data_o & ~keep_mask & ~(REG_W'(1) << 7)
                     & ~({{(REG_W-8-ADDR_W){1'b0}}, {ADDR_W{1'b1}}, 8'h00}));

  // R7: writes only inside a transfer
  a_r7_wr_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);
  // R4: strobe high in one write, cleared by the next
  a_r4_strobe_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && stb_now) |=> (wr_en_o && !stb_now));
  // R6: untouched bits hold between non-zero writes
  a_r6_keep_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_data_o != '0) |-> ((wr_data_o & keep_mask) == ($past(wr_data_o) & keep_mask)));
  // R7: done is a single pulse with busy low
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o ##1 !done_o));
  // R8: target latched for the whole transfer
  a_r8_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(phy_q) && $stable(addr_q)));
endmodule

bind phy_tune_writer ptw_checker #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .N_PHY(N_PHY), .PHY_W(PHY_W)
) u_ptw_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .wr_en_o  (wr_en_o),
  .wr_data_o(wr_data_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .phy_q    (phy_q),
  .addr_q   (addr_q)
);

// File: tb/phy_tune_writer_tb_top.sv
module phy_tune_writer_tb_top;
  localparam int          DW  = 8;
  localparam int          LW  = 4;
  localparam int          NP  = 4;
  localparam logic [31:0] RV  = 32'h5A5A_0022;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, zero_first_i = 1'b0;
  logic [1:0]  phy_idx_i = '0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [LW-1:0] len_i = '0;
  logic        wr_en_o, busy_o, done_o;
  logic [31:0] wr_data_o;

  int errors = 0, checks = 0, cyc = 0;
  logic [31:0] cap_q[$];
  logic [31:0] exp_q[$];
  logic [31:0] model;

  always #2.5 clk_i = ~clk_i;

  phy_tune_writer #(.DATA_W(DW), .N_PHY(NP), .RST_VAL(RV)) dut_i (.*);

  always @(negedge clk_i) if (wr_en_o) cap_q.push_back(wr_data_o);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // arithmetic model of the write list
  task automatic build(input int p, input logic [7:0] a, input logic [7:0] d, input int len, input bit z);
    int nb;
    exp_q.delete();
    nb = (len > DW) ? DW : len;
    if (z) begin model = '0; exp_q.push_back(model); end
    for (int i = 0; i < nb; i++) begin
      model[15:8] = a + 8'(i);                  exp_q.push_back(model);
      model[7] = d[i]; model[2*p] = 1'b0;       exp_q.push_back(model);
      model[2*p] = 1'b1;                        exp_q.push_back(model);
      model[2*p] = 1'b0;                        exp_q.push_back(model);
    end
  endtask

  task automatic run(input int p, input logic [7:0] a, input logic [7:0] d, input int len,
                     input bit z, input int poke, input string tag);
    int n, w;
    build(p, a, d, len, z);
    w = exp_q.size();
    cap_q.delete();
    @(negedge clk_i);
    phy_idx_i = 2'(p); addr_i = a; data_i = d; len_i = LW'(len); zero_first_i = z; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; n = 1;
    check(busy_o === 1'b1, {tag, " R7 busy after start"}, 32'(busy_o), 1);
    while (!done_o && n < 300) begin
      @(negedge clk_i); n++;
      if (poke != 0 && n == poke) begin
        phy_idx_i = ~phy_idx_i; addr_i = ~a; data_i = ~d; len_i = LW'(DW); zero_first_i = ~z;
        start_i = 1'b1;
      end
      if (poke != 0 && n == poke + 1) start_i = 1'b0;
    end
    check(n == w + 2, {tag, " R7 done cycle"}, 32'(n), 32'(w + 2));
    check(busy_o === 1'b0, {tag, " R7 busy low at done"}, 32'(busy_o), 0);
    @(negedge clk_i);
    check(done_o === 1'b0, {tag, " R7 done one cycle"}, 32'(done_o), 0);
    if (poke != 0) begin
      repeat (3) @(negedge clk_i);
      check(busy_o === 1'b0, {tag, " R8 no restart"}, 32'(busy_o), 0);
    end
    check(cap_q.size() == w, {tag, " R3 R5 R9 R10 write count"}, 32'(cap_q.size()), 32'(w));
    for (int i = 0; i < w && i < cap_q.size(); i++)
      if (cap_q[i] !== exp_q[i]) begin
        check(1'b0, $sformatf("%s R2 R3 R4 R6 write %0d", tag, i), cap_q[i], exp_q[i]);
        break;
      end
  endtask

  initial begin
    model = RV;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(busy_o === 1'b0 && done_o === 1'b0 && wr_en_o === 1'b0, "R1 reset flags",
          {29'd0, busy_o, done_o, wr_en_o}, 0);
    check(wr_data_o === RV, "R1 reset value", wr_data_o, RV);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(wr_data_o === RV && busy_o === 1'b0, "R1 idle after reset", wr_data_o, RV);

    // typical transfers, legacy variant first so R6 preserves upper bits
    run(0, 8'h0c, 8'h01, 1, 1'b0, 0, "cal");
    run(1, 8'h20, 8'h14, 5, 1'b0, 0, "txamp");
    run(2, 8'h2a, 8'h03, 2, 1'b0, 0, "disc");
    run(3, 8'h3c, 8'h00, 2, 1'b0, 0, "squelch_en");
    run(3, 8'h3c, 8'h02, 2, 1'b0, 0, "squelch_dis");
    run(2, 8'hFE, 8'hB6, 5, 1'b0, 0, "R2 wrap");
    run(1, 8'h40, 8'h5A, 0, 1'b0, 0, "R9 len0");
    run(0, 8'h10, 8'hC3, 15, 1'b0, 0, "R10 clamp");
    run(1, 8'h30, 8'h96, 6, 1'b0, 3, "R8 poke");

    // sweep: every PHY, both variants, lengths past DATA_W
    for (int v = 0; v < 2; v++)
      for (int p = 0; p < NP; p++)
        for (int l = 0; l <= DW + 2; l++)
          run(p, 8'(l * 8'h25 + p * 8'h40), 8'(p * 8'h3B + l * 8'h17 + v * 8'h61 + 8'h5C),
              l, 1'(v), 0, v ? "R5 sweep zero" : "sweep legacy");

    run(0, 8'h44, 8'h00, 0, 1'b1, 0, "R9 R5 len0 zero");
    run(3, 8'hF0, 8'hFF, 8, 1'b1, 4, "R8 poke zero");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule